// File: doc/BRIEF.md
# Sequencing ADC Serial Host Controller

This block is the host side of a four-wire synchronous serial link to an eight-channel, 12-bit successive-approximation converter. Each frame is a single chip-select window in which the host drives sixteen serial clocks. On the data-out line it shifts a 12-bit control word, most significant bit first, followed by four zero bits. On the data-in line it collects a 16-bit reply. The reply carries a header (a zero guard bit and a 3-bit channel tag) and then the 12-bit sample. The sample belongs to the conversion started by that same frame's chip-select fall, so there is no pipeline lag to account for.

The host splits each reply into channel, sample and a header-error flag. It attaches the coding and range settings that were sent in that frame's control word and offers the result on a valid/ready port. The serial clock half-period comes from a runtime divider input, in system clocks. A fixed quiet time, in system clocks, is kept between frames. Frames start either one per start pulse or back to back in continuous mode. A new frame never begins while an unaccepted result is still waiting on the output.

Top module: `adc_seq_host`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 1, `mosi` is 0 and `out_valid` is 0.
- R2: Each frame holds `cs_n` low and produces exactly 16 falling edges of `sclk`. `sclk` is high whenever `cs_n` is high.
- R3: Every phase while `cs_n` is low lasts H system clocks, where H is `div_half`, or 2 when `div_half` is below 2. The phases are the lead from the `cs_n` fall to the first `sclk` fall, each `sclk` low and high phase, and the tail from the last `sclk` rise to the `cs_n` rise.
- R4: Across the 16 `sclk` falling edges of a frame, `mosi` carries `ctrl_word[11:0]` MSB first, then four 0 bits. `mosi` changes only on `sclk` rising edges.
- R5: `miso` is sampled at each `sclk` rising edge. The 16 samples form the reply word, first bit = bit 15. `out_sample` is reply bits [11:0].
- R6: `out_chan` is reply bits [14:12]. `out_hdr_err` is 1 exactly when reply bit 15 is 1.
- R7: `out_twos` equals bit 0 and `out_wide` equals bit 1 of the control word sent in the same frame.
- R8: Between frames `cs_n` stays high for at least QUIET_CYC+1 system clocks. In continuous mode with `out_ready` held high, the gap is exactly QUIET_CYC+1.
- R9: While `cont_en` is 1, frames follow one another with no start pulse.
- R10: While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady and no new frame starts. Every result is delivered once, in order.
- R11: Start pulses that arrive during a frame are remembered as one pending frame. Several such pulses still give only one extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse requesting one frame |
| cont_en | input | 1 | Continuous frame mode |
| div_half | input | DIV_W | Serial clock half-period in system clocks (minimum 2) |
| ctrl_word | input | 12 | Control word sent in the next frame |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Result accepted by consumer |
| out_chan | output | 3 | Channel tag from the reply header |
| out_sample | output | 12 | Conversion sample |
| out_hdr_err | output | 1 | Guard bit of the header was nonzero |
| out_twos | output | 1 | Coding setting sent in this frame |
| out_wide | output | 1 | Range setting sent in this frame |

## Verification
The bench models the converter on the wire. It times every phase of the frame in system clocks at the smallest half-period, at the clamped value from a zero divider input, and at a wider one. A host that clamped wrongly or dropped one cycle would shorten a phase or miss a serial clock, which breaks the sixteen-edge count. Replies with the guard bit set, all-ones and all-zero samples, and several control words check the bit order and the header split. A shift that is off by one shows up as wrong channel or sample bits. Continuous runs measure the exact chip-select gap. Stalling the consumer must freeze the output and hold off the next frame, and a host that overwrote or skipped results would break the scoreboard order. Doubled start pulses during a frame must yield exactly one extra frame.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CTRL_BITS  = 12;
    localparam int DATA_BITS  = 12;
    localparam int CHAN_BITS  = 3;
    localparam int GUARD_BITS = FRAME_BITS - DATA_BITS - CHAN_BITS;
    localparam int CNT_BITS   = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_TAIL,
        PH_QUIET
    } phase_e;

    typedef struct packed {
        logic [CHAN_BITS-1:0] chan;
        logic [DATA_BITS-1:0] sample;
        logic                 hdr_err;
        logic                 twos;
        logic                 wide;
    } result_t;

endpackage

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] half_eff;
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        half_eff = (half < DIV_W'(2)) ? DIV_W'(2) : half;
        tick     = run && (cnt_q == half_eff - DIV_W'(1));
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: a phase is never shorter than two system clocks
    p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/adc_shift_pair.sv
module adc_shift_pair
    import adc_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic [CTRL_BITS-1:0]  ctrl,
    input  logic                  miso,
    output logic                  mosi,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic [CNT_BITS-1:0]   bit_cnt
);

    typedef struct packed {
        logic [FRAME_BITS-1:0] tx;
        logic [FRAME_BITS-1:0] rx;
        logic [CNT_BITS-1:0]   cnt;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.tx  = {ctrl, {(FRAME_BITS - CTRL_BITS){1'b0}}};
            sh_d.rx  = '0;
            sh_d.cnt = '0;
        end else if (step) begin
            sh_d.tx  = {sh_q.tx[FRAME_BITS-2:0], 1'b0};
            sh_d.rx  = {sh_q.rx[FRAME_BITS-2:0], miso};
            sh_d.cnt = sh_q.cnt + CNT_BITS'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign mosi    = sh_q.tx[FRAME_BITS-1];
    assign rx_word = sh_q.rx;
    assign bit_cnt = sh_q.cnt;

    // R5: the controller never asks for a seventeenth sample
    p_step_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (sh_q.cnt < CNT_BITS'(FRAME_BITS)));

endmodule

// File: rtl/adc_result_slot.sv
module adc_result_slot
    import adc_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [FRAME_BITS-1:0] word,
    input  logic                  twos_in,
    input  logic                  wide_in,
    input  logic                  out_ready,
    output logic                  out_valid,
    output result_t               out_res
);

    typedef struct packed {
        logic    valid;
        result_t res;
    } slot_t;

    slot_t   sl_d, sl_q;
    result_t dec;
    logic    guard_err;

    generate
        if (GUARD_BITS > 0) begin : g_guard
            assign guard_err = |word[FRAME_BITS-1 -: GUARD_BITS];
        end else begin : g_noguard
            assign guard_err = 1'b0;
        end
    endgenerate

    always_comb begin
        dec.chan    = word[DATA_BITS +: CHAN_BITS];
        dec.sample  = word[DATA_BITS-1:0];
        dec.hdr_err = guard_err;
        dec.twos    = twos_in;
        dec.wide    = wide_in;

        sl_d = sl_q;
        if (sl_q.valid && out_ready) sl_d.valid = 1'b0;
        if (push) begin
            sl_d.valid = 1'b1;
            sl_d.res   = dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign out_valid = sl_q.valid;
    assign out_res   = sl_q.res;

    // R10: a stalled result stays put
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

    // R10: a new result never lands on an unaccepted one
    p_no_overwrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!sl_q.valid || out_ready));

endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int QUIET_CYC = 7,
    parameter int FMT_BIT   = 0,
    parameter int SPAN_BIT  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 cont_en,
    input  logic [DIV_W-1:0]     div_half,
    input  logic [CTRL_BITS-1:0] ctrl_word,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 mosi,
    input  logic                 miso,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [CHAN_BITS-1:0] out_chan,
    output logic [DATA_BITS-1:0] out_sample,
    output logic                 out_hdr_err,
    output logic                 out_twos,
    output logic                 out_wide
);

    localparam int QUIET_EFF = (QUIET_CYC < 1) ? 1 : QUIET_CYC;
    localparam int QCNT_W    = $clog2(QUIET_EFF + 1);

    typedef struct packed {
        phase_e            ph;
        logic              cs_n;
        logic              sclk;
        logic              pend;
        logic              twos;
        logic              wide;
        logic [QCNT_W-1:0] qcnt;
    } ctl_t;

    ctl_t                  st_d, st_q;
    logic                  tick, run, launch, slot_free;
    logic                  load, step, push;
    logic [FRAME_BITS-1:0] rx_word;
    logic [CNT_BITS-1:0]   bit_cnt;
    result_t               res;

    assign run       = (st_q.ph == PH_LEAD) || (st_q.ph == PH_LOW) ||
                       (st_q.ph == PH_HIGH) || (st_q.ph == PH_TAIL);
    assign slot_free = !out_valid || out_ready;
    assign launch    = (st_q.ph == PH_IDLE) && (st_q.pend || cont_en) && slot_free;

    always_comb begin
        st_d      = st_q;
        load      = 1'b0;
        step      = 1'b0;
        push      = 1'b0;
        st_d.pend = st_q.pend | start;
        case (st_q.ph)
            PH_IDLE: begin
                if (launch) begin
                    st_d.ph   = PH_LEAD;
                    st_d.cs_n = 1'b0;
                    st_d.pend = start;
                    st_d.twos = ctrl_word[FMT_BIT];
                    st_d.wide = ctrl_word[SPAN_BIT];
                    load      = 1'b1;
                end
            end
            PH_LEAD: begin
                if (tick) begin
                    st_d.sclk = 1'b0;
                    st_d.ph   = PH_LOW;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    st_d.sclk = 1'b1;
                    step      = 1'b1;
                    st_d.ph   = (bit_cnt == CNT_BITS'(FRAME_BITS - 1)) ? PH_TAIL : PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    st_d.sclk = 1'b0;
                    st_d.ph   = PH_LOW;
                end
            end
            PH_TAIL: begin
                if (tick) begin
                    st_d.cs_n = 1'b1;
                    st_d.qcnt = '0;
                    st_d.ph   = PH_QUIET;
                    push      = 1'b1;
                end
            end
            PH_QUIET: begin
                if (st_q.qcnt == QCNT_W'(QUIET_EFF - 1)) st_d.ph = PH_IDLE;
                else                                     st_d.qcnt = st_q.qcnt + QCNT_W'(1);
            end
            default: st_d.ph = PH_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_QUIET;
            st_q.cs_n <= 1'b1;
            st_q.sclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    adc_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .half  (div_half),
        .tick  (tick)
    );

    adc_shift_pair u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .ctrl    (ctrl_word),
        .miso    (miso),
        .mosi    (mosi),
        .rx_word (rx_word),
        .bit_cnt (bit_cnt)
    );

    adc_result_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .word      (rx_word),
        .twos_in   (st_q.twos),
        .wide_in   (st_q.wide),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_res   (res)
    );

    assign cs_n        = st_q.cs_n;
    assign sclk        = st_q.sclk;
    assign out_chan    = res.chan;
    assign out_sample  = res.sample;
    assign out_hdr_err = res.hdr_err;
    assign out_twos    = res.twos;
    assign out_wide    = res.wide;

    // Checker-side count of consecutive chip-select high cycles
    logic [QCNT_W:0] hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              hi_q <= '0;
        else if (!cs_n)                          hi_q <= '0;
        else if (hi_q < (QCNT_W + 1)'(QUIET_EFF)) hi_q <= hi_q + 1'b1;
    end

    // R2: the serial clock rests high outside a frame
    p_sclk_rest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R2: a frame closes only after all sixteen bits
    p_full_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (bit_cnt == CNT_BITS'(FRAME_BITS)));

    // R8: the quiet gap is honoured before every frame
    p_quiet_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_q >= (QCNT_W + 1)'(QUIET_EFF)));

    // R10: no frame starts over a waiting result
    p_no_launch_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(!out_valid || out_ready));

endmodule

// File: tb/test_adc_seq_host.sv
module test_adc_seq_host;
    import adc_seq_pkg::*;

    localparam int DIV_W = 8;
    localparam int QUIET = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n, start, cont_en, out_ready, miso;
    logic [DIV_W-1:0] div_half;
    logic [11:0]      ctrl_word;
    logic             cs_n, sclk, mosi, out_valid, out_hdr_err, out_twos, out_wide;
    logic [2:0]       out_chan;
    logic [11:0]      out_sample;

    adc_seq_host #(.DIV_W(DIV_W), .QUIET_CYC(QUIET), .FMT_BIT(0), .SPAN_BIT(1)) i_adc_seq_host (
        .clk(clk), .rst_n(rst_n), .start(start), .cont_en(cont_en),
        .div_half(div_half), .ctrl_word(ctrl_word),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_chan(out_chan), .out_sample(out_sample), .out_hdr_err(out_hdr_err),
        .out_twos(out_twos), .out_wide(out_wide)
    );

    typedef struct {
        logic [2:0]  chan;
        logic [11:0] sample;
        logic        err;
        logic        twos;
        logic        wide;
    } exp_t;

    exp_t        exp_q[$];
    logic [15:0] resp_q[$];
    logic [15:0] ctrl_q[$];

    int checks = 0, fails = 0;
    int h_exp = 3, fallcnt = 0;
    bit exact_gap = 0, finished = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic expect_frame(input logic [2:0] ch, input logic [11:0] smp,
                                input logic bad, input logic [11:0] cw);
        exp_t e;
        e.chan = ch; e.sample = smp; e.err = bad; e.twos = cw[0]; e.wide = cw[1];
        exp_q.push_back(e);
        resp_q.push_back({bad, ch, smp});
        ctrl_q.push_back({cw, 4'b0000});
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_drain();
        wait (exp_q.size() == 0);
        wait (cs_n === 1'b1);
        repeat (QUIET + 4) @(posedge clk);
    endtask

    task automatic set_div(input int d);
        @(posedge clk); #1;
        div_half = DIV_W'(d);
        h_exp    = (d < 2) ? 2 : d;
    endtask

    // Converter model: drives reply on sclk falls, records mosi on sclk falls
    initial begin
        logic [15:0] word, exp_c, rx;
        miso = 1'b0;
        forever begin
            @(negedge cs_n);
            word  = (resp_q.size() != 0) ? resp_q.pop_front() : 16'h0000;
            exp_c = (ctrl_q.size() != 0) ? ctrl_q.pop_front() : 16'h0000;
            rx    = '0;
            for (int k = 0; k < 16; k++) begin
                @(negedge sclk);
                rx   = {rx[14:0], mosi};
                miso = word[15-k];
            end
            @(posedge cs_n);
            chk(rx == exp_c, "R4 control word on mosi", rx, exp_c);
            miso = 1'b0;
        end
    end

    // Wire timing monitor
    initial begin
        logic pcs, psck;
        int   seg, falls;
        pcs = 1'b1; psck = 1'b1; seg = 0; falls = 0;
        forever begin
            @(negedge clk);
            if (rst_n && (cs_n !== pcs || sclk !== psck)) begin
                if (!pcs)
                    chk(seg == h_exp, "R3 phase length", seg, h_exp);
                if (pcs && !cs_n) begin
                    if (exact_gap) chk(seg == QUIET + 1, "R8 exact gap", seg, QUIET + 1);
                    else           chk(seg >= QUIET + 1, "R8 minimum gap", seg, QUIET + 1);
                    falls = 0;
                    fallcnt++;
                end
                if (!pcs && cs_n)
                    chk(falls == 16, "R2 sclk falls per frame", falls, 16);
                if (psck && !sclk) falls++;
                seg = 1;
            end else begin
                seg++;
            end
            pcs  = cs_n;
            psck = sclk;
        end
    end

    // Scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected result", out_sample, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(out_chan == e.chan, "R6 channel tag", out_chan, e.chan);
                    chk(out_sample == e.sample, "R5 sample", out_sample, e.sample);
                    chk(out_hdr_err == e.err, "R6 header error", out_hdr_err, e.err);
                    chk(out_twos == e.twos, "R7 coding flag", out_twos, e.twos);
                    chk(out_wide == e.wide, "R7 range flag", out_wide, e.wide);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hang expected completion");
            summary();
        end
    end

    initial begin
        int base;
        logic [11:0] held;
        rst_n = 1'b0; start = 1'b0; cont_en = 1'b0; out_ready = 1'b1;
        div_half = DIV_W'(3); ctrl_word = '0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
        chk(sclk == 1'b1, "R1 sclk reset", sclk, 1);
        chk(mosi == 1'b0, "R1 mosi reset", mosi, 0);
        chk(out_valid == 1'b0, "R1 out_valid reset", out_valid, 0);

        // Single frames, several patterns and half-periods
        set_div(3); ctrl_word = 12'hB37;
        expect_frame(3'd5, 12'hA5C, 1'b0, 12'hB37); pulse_start(); wait_drain();
        ctrl_word = 12'h402;
        expect_frame(3'd0, 12'h000, 1'b1, 12'h402); pulse_start(); wait_drain();
        set_div(0); ctrl_word = 12'h001;
        expect_frame(3'd7, 12'hFFF, 1'b0, 12'h001); pulse_start(); wait_drain();
        set_div(5); ctrl_word = 12'h8F0;
        expect_frame(3'd2, 12'h123, 1'b1, 12'h8F0); pulse_start(); wait_drain();

        // R9: continuous mode with exact quiet gap
        set_div(2); ctrl_word = 12'h555;
        base = fallcnt;
        expect_frame(3'd1, 12'h3C3, 1'b0, 12'h555);
        expect_frame(3'd6, 12'hC3C, 1'b0, 12'h555);
        expect_frame(3'd4, 12'h800, 1'b0, 12'h555);
        cont_en = 1'b1;
        wait (fallcnt == base + 1);
        exact_gap = 1'b1;
        wait (fallcnt == base + 3);
        exact_gap = 1'b0;
        @(posedge clk); #1 cont_en = 1'b0;
        wait_drain();
        repeat (40) @(posedge clk);
        chk(fallcnt == base + 3, "R9 continuous frame count", fallcnt - base, 3);

        // R10: back-pressure holds the result and the next frame
        set_div(3); ctrl_word = 12'h2A6;
        base = fallcnt;
        @(posedge clk); #1 out_ready = 1'b0;
        expect_frame(3'd3, 12'h7E1, 1'b0, 12'h2A6);
        expect_frame(3'd5, 12'h00F, 1'b1, 12'h2A6);
        expect_frame(3'd2, 12'hF00, 1'b0, 12'h2A6);
        cont_en = 1'b1;
        wait (fallcnt == base + 1);
        wait (out_valid === 1'b1);
        @(negedge clk);
        held = out_sample;
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(fallcnt == base + 1, "R10 no frame while stalled", fallcnt - base, 1);
        chk(out_valid == 1'b1, "R10 valid held", out_valid, 1);
        chk(out_sample == held && held == 12'h7E1, "R10 sample held", out_sample, 12'h7E1);
        @(posedge clk); #1 out_ready = 1'b1;
        wait (fallcnt == base + 3);
        @(posedge clk); #1 cont_en = 1'b0;
        wait_drain();

        // R11: repeated start pulses during a frame collapse to one
        ctrl_word = 12'h0C3;
        base = fallcnt;
        expect_frame(3'd6, 12'h5A5, 1'b0, 12'h0C3);
        expect_frame(3'd1, 12'hA5A, 1'b0, 12'h0C3);
        pulse_start();
        wait (fallcnt == base + 1);
        pulse_start();
        repeat (3) @(posedge clk);
        pulse_start();
        wait_drain();
        repeat (120) @(posedge clk);
        chk(fallcnt == base + 2, "R11 pending start collapse", fallcnt - base, 2);
        chk(exp_q.size() == 0, "R10 all results delivered", exp_q.size(), 0);

        summary();
    end

endmodule